// File: doc/BRIEF.md
# Thirty-Two-Bit Integer ALU with Signed Compare and Barrel Shifts

This block is the purely combinational arithmetic and logic unit of a small load/store integer core. Each evaluation takes two operand words and a four-bit function selector, and yields one result word in the same delta cycle. It has no clock and no internal state. The surrounding datapath chooses the operands, sign-extends any literal constants, and writes the result back.

The operations are add, subtract, three signed compares, bitwise AND/OR/XOR, and three shifts: left, logical right and arithmetic right. The compares do not use a separate magnitude comparator. They reuse the subtractor and read its negative, zero and overflow flags. Less-than is negative XOR overflow, and less-or-equal adds zero to that. This keeps the verdict correct when the operands sit at opposite ends of the signed range and the difference overflows. A compare writes 1 or 0 into the whole result word. A shift takes its distance from the low five bits of the second operand only.

Top module: `alu_core`

## Requirements
- R1: Selector 0 (add) returns opa + opb modulo 2^32 with no overflow indication; 0xAAAAAAAA + 0x55555555 = 0xFFFFFFFF and 0xAAAAAAAA + 0xAAAAAAAA = 0x55555554.
- R2: Selector 1 (subtract) returns opa - opb modulo 2^32; 1 - 1 = 0 (borrow runs through every bit) and 0 - 1 = 0xFFFFFFFF.
- R3: Selector 4 (equal) returns 1 when opa equals opb and 0 otherwise; 0 vs 0 gives 1, 0 vs 0xFFFFFFFF gives 0.
- R4: Selector 5 (signed less-than) returns 1 when opa < opb as two's-complement numbers; 0 < 1 gives 1, 0 < -1 gives 0, 0x80000000 < 0x7FFFFFFF gives 1.
- R5: Selector 6 (signed less-or-equal) returns 1 when opa <= opb as two's-complement numbers; 0 <= 0 gives 1, 0 <= -1 gives 0, 0x80000000 <= 0x7FFFFFFF gives 1 and 0x7FFFFFFF <= 0x80000000 gives 0.
- R6: Every compare result has bits 31 down to 1 equal to zero, so the whole word reads 0x00000001 or 0x00000000.
- R7: Selectors 8, 9 and 10 return bitwise AND, OR and XOR; 0x0F0F with 0x7F00 gives 0x0F00, 0x7F0F and 0x700F.
- R8: Every shift uses only opb[4:0] as its distance; 1 shifted left by 32 gives 1, and by 33 gives 2.
- R9: Selector 12 (shift left) fills with zeros; 1 shifted left by 31 gives 0x80000000.
- R10: Selector 13 (logical shift right) fills with zeros; 0x80000000 shifted by 17 gives 0x00004000.
- R11: Selector 14 (arithmetic shift right) fills with opa[31]; 0x80000000 shifted by 17 gives 0xFFFFC000, and 0x40000000 shifted by 4 gives 0x04000000.
- R12: The unused selector codes 2, 3, 7, 11 and 15 return 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn_sel | input | 4 | Function selector (encodings in R1 to R12) |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand; its low five bits are the shift distance |
| result | output | 32 | Result word |

## Verification
The hardest case to reach is a compare whose internal subtraction overflows. Only operand pairs of opposite sign and large magnitude reach it, and a design that reads the raw sign bit gives the wrong answer exactly there. The directed tasks apply 0x80000000 against 0x7FFFFFFF in both orders for less-than and for less-or-equal. A sweep driven by a pseudo-random sequence then mixes in those extreme values with random words. Shift distances at and above 32 are applied on purpose so that the upper count bits must be ignored.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int FN_W = 4;

    typedef enum logic [FN_W-1:0] {
        FN_ADD   = 4'd0,
        FN_SUB   = 4'd1,
        FN_CMPEQ = 4'd4,
        FN_CMPLT = 4'd5,
        FN_CMPLE = 4'd6,
        FN_AND   = 4'd8,
        FN_OR    = 4'd9,
        FN_XOR   = 4'd10,
        FN_SHL   = 4'd12,
        FN_SHR   = 4'd13,
        FN_SRA   = 4'd14
    } alu_fn_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic                 [W-1:0] a,
    input  logic                 [W-1:0] b,
    input  logic                         sub,
    output logic                 [W-1:0] sum,
    output alu_pkg::alu_flags_t          flags
);

    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff       = sub ? ~b : b;
        wide        = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum         = wide[W-1:0];
        flags.carry = wide[W];
        flags.neg   = sum[W-1];
        flags.zero  = (sum == '0);
        flags.ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end

    always_comb begin
        if (!$isunknown({a, b, sub}) && !sub) begin
            AST_ADD_WRAP: assert (sum - b == a); // R1
        end
        if (!$isunknown({a, b, sub}) && sub) begin
            AST_SUB_WRAP: assert (sum + b == a); // R2
        end
    end

endmodule

// File: rtl/alu_compare.sv
module alu_compare (
    input  alu_pkg::alu_flags_t flags,
    input  alu_pkg::alu_fn_e    fn,
    output logic                hit
);

    logic less;

    always_comb begin
        less = flags.neg ^ flags.ovf;
        case (fn)
            alu_pkg::FN_CMPEQ: hit = flags.zero;
            alu_pkg::FN_CMPLT: hit = less;
            alu_pkg::FN_CMPLE: hit = less | flags.zero;
            default:           hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W = 32
) (
    input  logic             [W-1:0] a,
    input  logic             [W-1:0] b,
    input  alu_pkg::alu_fn_e         fn,
    output logic             [W-1:0] y
);

    always_comb begin
        case (fn)
            alu_pkg::FN_AND: y = a & b;
            alu_pkg::FN_OR:  y = a | b;
            alu_pkg::FN_XOR: y = a ^ b;
            default:         y = '0;
        endcase
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] amt,
    input  logic           go_left,
    input  logic           arith,
    output logic [W-1:0]   y
);

    logic [W-1:0] stage [0:SHW];
    logic [W-1:0] a_rev;
    logic [W-1:0] out_rev;
    logic         fill;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            a_rev[i]   = a[W-1-i];
            out_rev[i] = stage[SHW][W-1-i];
        end
    end

    assign fill     = arith & ~go_left & a[W-1];
    assign stage[0] = go_left ? a_rev : a;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign stage[k+1] = amt[k] ? {{SH{fill}}, stage[k][W-1:SH]} : stage[k];
    end

    assign y = go_left ? out_rev : stage[SHW];

endmodule

// File: rtl/alu_core.sv
module alu_core #(
    parameter int W = 32
) (
    input  logic [3:0]   fn_sel,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] result
);

    import alu_pkg::*;

    localparam int SHW = $clog2(W);

    alu_fn_e      fn;
    logic         do_sub;
    logic         sh_left;
    logic         sh_arith;
    logic [W-1:0] sum;
    alu_flags_t   flags;
    logic         cmp_hit;
    logic [W-1:0] bool_y;
    logic [W-1:0] shift_y;

    always_comb begin
        fn       = alu_fn_e'(fn_sel);
        do_sub   = (fn != FN_ADD);
        sh_left  = (fn == FN_SHL);
        sh_arith = (fn == FN_SRA);
    end

    alu_addsub #(.W(W)) i_addsub (
        .a     (opa),
        .b     (opb),
        .sub   (do_sub),
        .sum   (sum),
        .flags (flags)
    );

    alu_compare i_compare (
        .flags (flags),
        .fn    (fn),
        .hit   (cmp_hit)
    );

    alu_logic #(.W(W)) i_logic (
        .a  (opa),
        .b  (opb),
        .fn (fn),
        .y  (bool_y)
    );

    alu_shifter #(.W(W), .SHW(SHW)) i_shifter (
        .a       (opa),
        .amt     (opb[SHW-1:0]),
        .go_left (sh_left),
        .arith   (sh_arith),
        .y       (shift_y)
    );

    always_comb begin
        case (fn)
            FN_ADD, FN_SUB:              result = sum;
            FN_CMPEQ, FN_CMPLT, FN_CMPLE: result = {{(W-1){1'b0}}, cmp_hit};
            FN_AND, FN_OR, FN_XOR:       result = bool_y;
            FN_SHL, FN_SHR, FN_SRA:      result = shift_y;
            default:                     result = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({fn_sel, opa, opb})) begin
            if (fn == FN_CMPEQ) begin
                AST_CMP_EQ: assert (cmp_hit == (opa == opb)); // R3
            end
            if (fn == FN_CMPLT) begin
                AST_CMP_LT: assert (cmp_hit == ($signed(opa) < $signed(opb))); // R4
            end
            if (fn == FN_CMPLE) begin
                AST_CMP_LE: assert (cmp_hit == ($signed(opa) <= $signed(opb))); // R5
            end
            if (fn == FN_SHL) begin
                AST_SHL: assert (result == (opa << opb[SHW-1:0])); // R9
            end
            if (fn == FN_SHR) begin
                AST_SHR: assert (result == (opa >> opb[SHW-1:0])); // R10
            end
            if (fn == FN_SRA) begin
                AST_SRA: assert (result == W'($signed(opa) >>> opb[SHW-1:0])); // R11
            end
        end
    end

endmodule

// File: tb/test_alu_core.sv
module test_alu_core;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic [3:0]   fn_sel;
    logic [W-1:0] opa;
    logic [W-1:0] opb;
    logic [W-1:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_core #(.W(W)) i_alu_core (
        .fn_sel (fn_sel),
        .opa    (opa),
        .opb    (opb),
        .result (result)
    );

    task automatic apply_chk(input string tag, input logic [3:0] f,
                             input logic [W-1:0] a, input logic [W-1:0] b,
                             input logic [W-1:0] exp);
        @(negedge clk);
        fn_sel = f;
        opa    = a;
        opb    = b;
        #1;
        n_checks++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s: fn=%0d a=%h b=%h actual=%h expected=%h",
                     tag, f, a, b, result, exp);
        end
    endtask

    task automatic t_reset_state();
        apply_chk("R1 idle zero", 4'd0, 32'h0, 32'h0, 32'h0);
    endtask

    task automatic t_add();
        apply_chk("R1", 4'd0, 32'hAAAAAAAA, 32'h55555555, 32'hFFFFFFFF);
        apply_chk("R1", 4'd0, 32'hAAAAAAAA, 32'hAAAAAAAA, 32'h55555554);
        apply_chk("R1", 4'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000);
    endtask

    task automatic t_sub();
        apply_chk("R2", 4'd1, 32'h1, 32'h1, 32'h0);
        apply_chk("R2", 4'd1, 32'h0, 32'h1, 32'hFFFFFFFF);
        apply_chk("R2", 4'd1, 32'h80000000, 32'h1, 32'h7FFFFFFF);
    endtask

    task automatic t_cmp_eq();
        apply_chk("R3", 4'd4, 32'h0, 32'h0, 32'h1);
        apply_chk("R3", 4'd4, 32'h0, 32'hFFFFFFFF, 32'h0);
        apply_chk("R3 R6", 4'd4, 32'h12345678, 32'h12345678, 32'h1);
    endtask

    task automatic t_cmp_lt();
        apply_chk("R4", 4'd5, 32'h0, 32'h1, 32'h1);
        apply_chk("R4", 4'd5, 32'h0, 32'hFFFFFFFF, 32'h0);
        apply_chk("R4 ovf", 4'd5, 32'h80000000, 32'h7FFFFFFF, 32'h1);
        apply_chk("R4 ovf", 4'd5, 32'h7FFFFFFF, 32'h80000000, 32'h0);
        apply_chk("R4", 4'd5, 32'h5, 32'h5, 32'h0);
    endtask

    task automatic t_cmp_le();
        apply_chk("R5", 4'd6, 32'h0, 32'h0, 32'h1);
        apply_chk("R5", 4'd6, 32'h0, 32'hFFFFFFFF, 32'h0);
        apply_chk("R5 ovf", 4'd6, 32'h80000000, 32'h7FFFFFFF, 32'h1);
        apply_chk("R5 ovf", 4'd6, 32'h7FFFFFFF, 32'h80000000, 32'h0);
    endtask

    task automatic t_bool();
        apply_chk("R7 and", 4'd8,  32'h0F0F, 32'h7F00, 32'h0F00);
        apply_chk("R7 or",  4'd9,  32'h0F0F, 32'h7F00, 32'h7F0F);
        apply_chk("R7 xor", 4'd10, 32'h0F0F, 32'h7F00, 32'h700F);
    endtask

    task automatic t_shifts();
        apply_chk("R8", 4'd12, 32'h1, 32'd32, 32'h1);
        apply_chk("R8", 4'd12, 32'h1, 32'd33, 32'h2);
        apply_chk("R8", 4'd13, 32'h80000000, 32'hFFFFFFE0, 32'h80000000);
        apply_chk("R9", 4'd12, 32'h1, 32'd31, 32'h80000000);
        apply_chk("R10", 4'd13, 32'h80000000, 32'd17, 32'h00004000);
        apply_chk("R11", 4'd14, 32'h80000000, 32'd17, 32'hFFFFC000);
        apply_chk("R11", 4'd14, 32'h40000000, 32'd4, 32'h04000000);
    endtask

    task automatic t_undefined();
        apply_chk("R12", 4'd2,  32'hDEADBEEF, 32'h1234, 32'h0);
        apply_chk("R12", 4'd3,  32'hDEADBEEF, 32'h1234, 32'h0);
        apply_chk("R12", 4'd7,  32'hDEADBEEF, 32'h1234, 32'h0);
        apply_chk("R12", 4'd11, 32'hDEADBEEF, 32'h1234, 32'h0);
        apply_chk("R12", 4'd15, 32'hDEADBEEF, 32'h1234, 32'h0);
    endtask

    function automatic logic [W-1:0] model(input logic [3:0] f,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
        case (f)
            4'd0:  return a + b;
            4'd1:  return a - b;
            4'd4:  return {31'b0, a == b};
            4'd5:  return {31'b0, $signed(a) < $signed(b)};
            4'd6:  return {31'b0, $signed(a) <= $signed(b)};
            4'd8:  return a & b;
            4'd9:  return a | b;
            4'd10: return a ^ b;
            4'd12: return a << b[4:0];
            4'd13: return a >> b[4:0];
            4'd14: return W'($signed(a) >>> b[4:0]);
            default: return '0;
        endcase
    endfunction

    task automatic t_sweep();
        logic [31:0] lfsr = 32'h1;
        for (int n = 0; n < 600; n++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            logic [3:0]   f;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b = lfsr;
            f = 4'(n % 16);
            if (n % 7 == 0) a = 32'h80000000;
            if (n % 11 == 0) b = 32'h7FFFFFFF;
            apply_chk("R1 R2 R4 R5 R6 R11 sweep", f, a, b, model(f, a, b));
        end
    endtask

    initial begin
        fn_sel = 4'd0;
        opa    = '0;
        opb    = '0;
        t_reset_state();
        t_add();
        t_sub();
        t_cmp_eq();
        t_cmp_lt();
        t_cmp_le();
        t_bool();
        t_shifts();
        t_undefined();
        t_sweep();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule